// File: doc/BRIEF.md
# Table-driven floppy bit sequencer

This block is the bit engine of a self-clocked floppy disk interface. A 4-bit sequencer state and an 8-bit data latch advance together on every tick of the sequencer clock (2 MHz in the target system). Each tick, a constant 256-entry table is addressed by five things: the current state, the direction bit, the shift/load bit, the latch MSB and the synchronized disk pulse. The entry it returns names the next state and one operation on the latch.

In read direction the block turns a stream of flux pulses into bytes. Each bit cell lasts eight clocks: a pulse in the cell is a 1 and a silent cell is a 0. A byte is finished when a 1 reaches the latch MSB. The finished byte is then held for the CPU until the next pulse arrives. That pulse becomes the leading 1 of the following byte, and the latch is cleared and rebuilt around it.

In write direction the block loads a byte from the CPU bus and sends it MSB first, one bit per eight clocks. The write line is the state MSB, and it toggles at a bit boundary exactly when the bit being sent is 1. If the CPU does not reload in time, the latch keeps shifting and zeros go out. In read direction with load selected, the latch instead samples the write-protect sense line on every tick.

Top module: `disk_bit_sequencer`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), the latch reads 0x00, the write line reads 0, and the sequencer state is 0.
- R2: Each table entry is a byte: bits [7:4] give the next state and bits [3:0] give the latch operation. The operation codes are 0x8 no-op, 0x0 clear, 0x9 shift left with 0 in, 0xD shift left with 1 in, 0xB load from cpu_data, and 0xA shift right with wprot entering bit 7. The table address is {state[3:0], wr_mode, ld_mode, latch bit 7, synchronized pulse}.
- R3: rd_pulse_raw passes through two flip-flops before it reaches the table. In the first byte after reset, a pulse captured at clock edge 1 shifts a 1 into the latch at edge 6.
- R4: With wr_mode=0 and ld_mode=1, every clock shifts the latch right with wprot entering bit 7, and the next state is 0.
- R5: In read-shift mode with no pulses after reset, edge 2 shifts in a 1 (latch 0x01). After that, a 0 is shifted in every 8 clocks, until 0x80 is reached at edge 58.
- R6: In read-shift mode, a latch with bit 7 set is held unchanged for as long as no pulse arrives.
- R7: With pulses placed on 8-clock cells (pulse = 1, no pulse = 0), the pulse that ends a hold is the leading 1 of the next byte. Bytes 0xAA, 0x96 and 0xFF sent back to back each appear in full with bit 7 set.
- R8: With wr_mode=1 and ld_mode=1, states 2 and 10 load cpu_data into the latch.
- R9: With wr_mode=1 and ld_mode=0, states 2 and 10 shift the latch left with 0 in. Every write state whose low three bits are not 7 advances the state by one.
- R10: wr_out is state bit 3. In write direction it toggles on leaving a state whose low bits are 7 if latch bit 7 is 1, and otherwise holds. This sends one bit per 8 clocks, MSB first, beginning at edge 8 after reset.
- R11: Without a reload, the latch empties to 0x00 after eight shifts and the write line stops toggling.
- R12: In write direction, rd_pulse_raw has no effect on the latch or the write line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_mode | input | 1 | 1 = write direction, 0 = read direction |
| ld_mode | input | 1 | 1 = load selected, 0 = shift selected |
| rd_pulse_raw | input | 1 | Unsynchronized flux pulse from the read head |
| wprot | input | 1 | Write-protect sense line |
| cpu_data | input | 8 | Byte from the CPU bus for loading |
| latch_q | output | 8 | Data latch contents |
| wr_out | output | 1 | Write line (sequencer state MSB) |

## Verification
The hardest state to reach from the ports is the release of a held byte. The next byte's leading pulse has to arrive while the previous byte sits with bit 7 set, and the bit that follows it may be either a pulse (which takes the clear path through states D, E, F) or a silence (which clears at state C). Neither path can be entered directly. To reach both, the stimulus places the first pulse right after reset so the sequencer locks on the first bit cell. It then streams 0xD5, 0xAA, 0x96 and 0xFF back to back on exact 8-clock cells, so that each byte after the first starts from a hold and both release paths are used.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int SEQ_STATE_W = 4;

  typedef enum logic [3:0] {
    OP_CLR = 4'h0,
    OP_NOP = 4'h8,
    OP_SL0 = 4'h9,
    OP_SR  = 4'hA,
    OP_LD  = 4'hB,
    OP_SL1 = 4'hD
  } seq_op_e;

  typedef struct packed {
    logic [SEQ_STATE_W-1:0] nxt;
    seq_op_e                op;
  } seq_word_t;

  // Choose one of four table bytes by latch MSB and pulse.
  function automatic logic [7:0] pick4(input logic [7:0] lo_pulse,
                                       input logic [7:0] lo_quiet,
                                       input logic [7:0] hi_pulse,
                                       input logic [7:0] hi_quiet,
                                       input logic msb, input logic pls);
    case ({msb, pls})
      2'b01:   return lo_pulse;
      2'b00:   return lo_quiet;
      2'b11:   return hi_pulse;
      default: return hi_quiet;
    endcase
  endfunction

  // Read direction with shift selected.
  function automatic logic [7:0] read_shift_entry(input logic [3:0] st,
                                                  input logic msb,
                                                  input logic pls);
    case (st)
      4'h0: return pick4(8'h18, 8'h18, 8'h18, 8'h18, msb, pls);
      4'h1: return pick4(8'h2D, 8'h2D, 8'h38, 8'h38, msb, pls);
      4'h2: return pick4(8'hD8, 8'h38, 8'h08, 8'h28, msb, pls);
      4'h3: return pick4(8'hD8, 8'h48, 8'h48, 8'h48, msb, pls);
      4'h4: return pick4(8'hD8, 8'h58, 8'hD8, 8'h58, msb, pls);
      4'h5: return pick4(8'hD8, 8'h68, 8'hD8, 8'h68, msb, pls);
      4'h6: return pick4(8'hD8, 8'h78, 8'hD8, 8'h78, msb, pls);
      4'h7: return pick4(8'hD8, 8'h88, 8'hD8, 8'h88, msb, pls);
      4'h8: return pick4(8'hD8, 8'h98, 8'hD8, 8'h98, msb, pls);
      4'h9: return pick4(8'hD8, 8'h29, 8'hD8, 8'hA8, msb, pls);
      4'hA: return pick4(8'hCD, 8'hBD, 8'hD8, 8'hB8, msb, pls);
      4'hB: return pick4(8'hD9, 8'h59, 8'hD8, 8'hC8, msb, pls);
      4'hC: return pick4(8'hD9, 8'hD9, 8'hD8, 8'hA0, msb, pls);
      4'hD: return pick4(8'hD8, 8'h08, 8'hE8, 8'hE8, msb, pls);
      4'hE: return pick4(8'hFD, 8'hFD, 8'hF8, 8'hF8, msb, pls);
      default: return pick4(8'hDD, 8'h4D, 8'hE0, 8'hE0, msb, pls);
    endcase
  endfunction

  // Write direction: counts through 8 states per bit; state MSB flips when
  // the outgoing bit is 1.
  function automatic logic [7:0] write_entry(input logic [3:0] st,
                                             input logic ld,
                                             input logic msb);
    logic [3:0] inc;
    inc = st + 4'd1;
    if (st[2:0] == 3'd7) return {st[3] ^ msb, 3'b000, OP_NOP};
    if (st[2:0] == 3'd2) return {inc, (ld ? OP_LD : OP_SL0)};
    return {inc, OP_NOP};
  endfunction

  // Full table entry for address {state, wr, ld, msb, pulse}.
  function automatic seq_word_t seq_entry(input logic [7:0] a);
    logic [3:0] st;
    logic       wr, ld, msb, pls;
    st  = a[7:4];
    wr  = a[3];
    ld  = a[2];
    msb = a[1];
    pls = a[0];
    if (wr)      return seq_word_t'(write_entry(st, ld, msb));
    else if (ld) return seq_word_t'({4'h0, OP_SR});
    else         return seq_word_t'(read_shift_entry(st, msb, pls));
  endfunction

endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/seq_rom.sv
module seq_rom
  import dseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output seq_word_t         word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [7:0] A = 8'(g);
    assign mem[g] = seq_entry(A);
  end

  assign word = seq_word_t'(mem[addr]);
endmodule

// File: rtl/shift_latch.sv
module shift_latch
  import dseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_op_e       op,
  input  logic [DW-1:0] din,
  input  logic          wp,
  output logic [DW-1:0] q
);
  function automatic logic [DW-1:0] apply_op(input seq_op_e o,
                                             input logic [DW-1:0] cur,
                                             input logic [DW-1:0] bus,
                                             input logic sense);
    case (o)
      OP_CLR:  return '0;
      OP_SL0:  return {cur[DW-2:0], 1'b0};
      OP_SL1:  return {cur[DW-2:0], 1'b1};
      OP_LD:   return bus;
      OP_SR:   return {sense, cur[DW-1:1]};
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= apply_op(op, q, din, wp);
  end
endmodule

// File: rtl/disk_bit_sequencer.sv
module disk_bit_sequencer
  import dseq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              ld_mode,
  input  logic              rd_pulse_raw,
  input  logic              wprot,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [DATA_W-1:0] latch_q,
  output logic              wr_out
);
  localparam int ST_W   = SEQ_STATE_W;
  localparam int ADDR_W = ST_W + 4;

  logic [ST_W-1:0]   seq_state;
  logic [ADDR_W-1:0] rom_addr;
  seq_word_t         word;
  seq_op_e           op;
  logic              rp_s;
  logic              qa;

  pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rd_pulse_raw),
    .q    (rp_s)
  );

  assign qa       = latch_q[DATA_W-1];
  assign rom_addr = {seq_state, wr_mode, ld_mode, qa, rp_s};

  seq_rom #(.ADDR_W(ADDR_W)) u_rom (
    .addr(rom_addr),
    .word(word)
  );

  assign op = word.op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_state <= '0;
    else        seq_state <= word.nxt;
  end

  shift_latch #(.DW(DATA_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .din  (cpu_data),
    .wp   (wprot),
    .q    (latch_q)
  );

  assign wr_out = seq_state[ST_W-1];
endmodule

// File: rtl/disk_bit_sequencer_chk.sv
module disk_bit_sequencer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_mode,
  input logic          ld_mode,
  input logic          wprot,
  input logic [DW-1:0] cpu_data,
  input logic [DW-1:0] latch_q,
  input logic          wr_out,
  input logic [3:0]    seq_state,
  input logic [3:0]    op,
  input logic          rp_s
);
  // R4
  rd_load_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && ld_mode) |=>
      (latch_q == {$past(wprot), $past(latch_q[DW-1:1])}) && (seq_state == 4'h0));

  // R10
  wr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && seq_state[2:0] == 3'd7) |=>
      (wr_out == ($past(wr_out) ^ $past(latch_q[DW-1]))));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && seq_state[2:0] != 3'd7) |=> $stable(wr_out));

  // R9
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && seq_state[2:0] != 3'd7) |=> (seq_state == $past(seq_state) + 4'd1));

  // R8
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && ld_mode && seq_state[2:0] == 3'd2) |=> (latch_q == $past(cpu_data)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode && !ld_mode && latch_q[DW-1] && !rp_s && seq_state == 4'h2) |=>
      ($stable(latch_q) && seq_state == 4'h2));

  // R2
  clr_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'h0) |=> (latch_q == '0));
endmodule

bind disk_bit_sequencer disk_bit_sequencer_chk #(.DW(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_mode  (wr_mode),
  .ld_mode  (ld_mode),
  .wprot    (wprot),
  .cpu_data (cpu_data),
  .latch_q  (latch_q),
  .wr_out   (wr_out),
  .seq_state(seq_state),
  .op       (op),
  .rp_s     (rp_s)
);

// File: tb/sim_disk_bit_sequencer.sv
module sim_disk_bit_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_mode = 1'b0;
  logic       ld_mode = 1'b0;
  logic       rd_pulse_raw = 1'b0;
  logic       wprot = 1'b0;
  logic [7:0] cpu_data = 8'h00;
  logic [7:0] latch_q;
  logic       wr_out;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  disk_bit_sequencer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mode     (wr_mode),
    .ld_mode     (ld_mode),
    .rd_pulse_raw(rd_pulse_raw),
    .wprot       (wprot),
    .cpu_data    (cpu_data),
    .latch_q     (latch_q),
    .wr_out      (wr_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Leaves the bench at the negedge where reset is released (edge 1 follows).
  task automatic do_reset(input logic wr, input logic ld, input logic [7:0] d);
    rst_n = 1'b0;
    wr_mode = wr;
    ld_mode = ld;
    cpu_data = d;
    rd_pulse_raw = 1'b0;
    wprot = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wr_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "latch in reset", latch_q, 8'h00);
    chk("R1", "write line in reset", {7'b0, wr_out}, 8'h00);
  endtask

  // Free running read with no pulses, then load-mode sampling of write protect.
  task automatic t_free_run();
    do_reset(1'b0, 1'b0, 8'h00);
    @(negedge clk);
    chk("R5", "after edge 1", latch_q, 8'h00);
    @(negedge clk);
    chk("R5", "after edge 2", latch_q, 8'h01);
    repeat (7) @(negedge clk);
    chk("R5", "after edge 9", latch_q, 8'h01);
    @(negedge clk);
    chk("R5", "after edge 10", latch_q, 8'h02);
    repeat (47) @(negedge clk);
    chk("R5", "after edge 57", latch_q, 8'h40);
    @(negedge clk);
    chk("R5", "after edge 58", latch_q, 8'h80);
    repeat (40) @(negedge clk);
    chk("R6", "held without pulses", latch_q, 8'h80);
    // R4: read direction, load selected
    ld_mode = 1'b1;
    wprot = 1'b1;
    @(negedge clk);
    chk("R4", "shift right wp=1", latch_q, 8'hC0);
    wprot = 1'b0;
    @(negedge clk);
    chk("R4", "shift right wp=0", latch_q, 8'h60);
    wprot = 1'b1;
    @(negedge clk);
    chk("R4", "shift right wp=1 again", latch_q, 8'hB0);
    chk("R4", "write line stays low", {7'b0, wr_out}, 8'h00);
  endtask

  // Sends bits [nbits-1:0] of b on 8-clock cells; checks the byte at the end.
  task automatic send_cells(input logic [7:0] b, input int nbits,
                            input logic [7:0] exp, input string req);
    for (int i = nbits - 1; i >= 0; i--) begin
      rd_pulse_raw = b[i];
      @(negedge clk);
      rd_pulse_raw = 1'b0;
      repeat (6) @(negedge clk);
      if (i == 0) chk(req, "assembled byte", latch_q, exp);
      @(negedge clk);
    end
  endtask

  task automatic t_decode();
    do_reset(1'b0, 1'b0, 8'h00);
    // first cell: pulse captured at edge 1, shift of a 1 at edge 6 (R3)
    rd_pulse_raw = 1'b1;
    @(negedge clk);
    rd_pulse_raw = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", "before synchronized shift", latch_q, 8'h01);
    @(negedge clk);
    chk("R3", "after synchronized shift", latch_q, 8'h03);
    repeat (2) @(negedge clk);
    // remaining six bits of 0xD5
    send_cells(8'h15, 6, 8'hD5, "R6");
    send_cells(8'hAA, 8, 8'hAA, "R7");
    send_cells(8'h96, 8, 8'h96, "R7");
    send_cells(8'hFF, 8, 8'hFF, "R7");
    repeat (40) @(negedge clk);
    chk("R6", "last byte held", latch_q, 8'hFF);
  endtask

  task automatic wtick();
    @(negedge clk);
    rd_pulse_raw = ~rd_pulse_raw;
  endtask

  task automatic t_write(input logic [7:0] b);
    logic       exp_wr;
    logic [7:0] exp_lat;
    do_reset(1'b1, 1'b1, b);
    repeat (3) wtick();
    chk("R8", "load at state 2", latch_q, b);
    ld_mode = 1'b0;
    exp_wr = 1'b0;
    exp_lat = b;
    repeat (4) wtick();
    chk("R10", "line before first bit", {7'b0, wr_out}, 8'h00);
    for (int k = 0; k < 8; k++) begin
      wtick();
      exp_wr = exp_wr ^ b[7 - k];
      chk("R10", "line at bit boundary", {7'b0, wr_out}, {7'b0, exp_wr});
      repeat (3) wtick();
      exp_lat = exp_lat << 1;
      chk("R9", "shift with 0 in", latch_q, exp_lat);
      repeat (4) wtick();
      chk("R12", "line stable mid-cell despite pulses", {7'b0, wr_out}, {7'b0, exp_wr});
    end
    chk("R11", "latch empty", latch_q, 8'h00);
    repeat (8) wtick();
    chk("R11", "no toggle on extra zero", {7'b0, wr_out}, {7'b0, exp_wr});
    repeat (8) wtick();
    chk("R11", "no toggle on second extra zero", {7'b0, wr_out}, {7'b0, exp_wr});
    rd_pulse_raw = 1'b0;
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_decode();
    t_write(8'hB2);
    t_write(8'h69);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule